// File: doc/BRIEF.md
# Three-Port Parallel I/O Controller

This block sits on a narrow register bus and drives three byte-wide general purpose ports, named A, B and C, plus a control register. Software sets the direction and operating mode of the ports with one control byte. In the plain mode, output bytes are held in latches and input bytes are read straight from the pins. In the strobed input mode, an external device pulses a strobe low to capture a byte. The block then reports that the byte is waiting and can raise an interrupt. Each pin is modelled as a separate input, output and output-enable bit, so the surrounding pad logic decides how the lines are driven.

The control register serves two purposes. When bit 7 of the written byte is high, the byte reconfigures every port. When bit 7 is low, the byte sets or clears a single port C bit. Port A belongs to group A together with the upper half of port C. Port B belongs to group B together with the lower half of port C. When a group runs in strobed mode, three of its port C bits are taken over for the strobe, the buffer-full flag and the interrupt request. The port C latch bit that sits under each strobe pin acts as that group's interrupt enable.

Top module: `pio_tri_port`

## Requirements
- R1: After reset, every output enable is low, every output latch is zero, both groups are in plain mode and both interrupt enables are off.
- R2: Register offsets are fixed: 0 is port A, 1 is port B, 2 is port C and 3 is control. In plain mode, a write to a port offset updates that port's output latch, and the latch appears on the port's output vector. The output enables of ports A and B are always all ones or all zeros.
- R3: A control write with bit 7 set decodes its fields as follows. Bits 6:5 select the group A mode, where any non-zero value means strobed and 00 means plain. Bit 4 sets the port A direction and bit 3 the port C upper-nibble direction. Bit 2 selects the group B mode, where 1 means strobed. Bit 1 sets the port B direction and bit 0 the port C lower-nibble direction. A direction bit of 1 means input. So 0x80 makes every port drive and 0x9B makes every port an input.
- R4: A read of a port in plain mode returns the pins for an input byte or nibble, and the output latch for an output byte or nibble.
- R5: Any control write with bit 7 set clears all three output latches, both buffer-full flags and both interrupt requests. It therefore also turns both interrupt enables off.
- R6: A control write with bit 7 clear writes bit 0 into the port C latch bit selected by bits 3:1. All other latch bits keep their values, so 0x09 sets bit 4 and 0x08 clears it.
- R7: In strobed mode, group A drives port C bit 5 as buffer-full and port C bit 3 as its interrupt request, and samples port C bit 4 as an active-low strobe. Port A never drives in this mode. A high-to-low transition on bit 4 captures the port A pins, and buffer-full reads 1 from the following cycle. Port A reads then return the captured byte, whatever the pins do afterwards.
- R8: The group A interrupt request rises only when the strobe goes back high while buffer-full is set and the enable (port C latch bit 4) is 1. With the enable at 0, buffer-full still rises but the request stays low.
- R9: Reading port A in strobed mode clears buffer-full and the interrupt request on the following clock edge.
- R10: Group B strobed mode works the same way on port B. Port C bit 2 is its strobe, bit 1 its buffer-full and bit 0 its interrupt request, and port C latch bit 2 is its enable (set with control byte 0x05). A read of port B clears the flags.
- R11: A port C read returns the handshake status in place of the pins on every bit a strobed group has taken over: the request on bits 3 and 0, buffer-full on bits 5 and 1, and the enable on bits 4 and 2.
- R12: A direct write to port C offset 2 changes only the bits that no strobed group has taken over. The enables and status bits keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 2 | Register offset |
| wr_en | input | 1 | Write strobe for the current cycle |
| rd_en | input | 1 | Read strobe; a read side effect occurs at the clock edge |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the current offset (combinational) |
| pa_in | input | 8 | Port A pin levels |
| pa_out | output | 8 | Port A drive value |
| pa_oe | output | 8 | Port A drive enables |
| pb_in | input | 8 | Port B pin levels |
| pb_out | output | 8 | Port B drive value |
| pb_oe | output | 8 | Port B drive enables |
| pc_in | input | 8 | Port C pin levels, including the strobe pins |
| pc_out | output | 8 | Port C drive value, including status bits |
| pc_oe | output | 8 | Port C drive enables |

## Verification
The configuration decode can go wrong in two visible ways. A bad field shows up on the output enables in the cycle after the control write. A stale latch shows up on the output vectors at the same moment. A fault in the strobe channel shows up as buffer-full or the request appearing on port C one cycle too early, one cycle too late, or not at all, or as a port A or B read returning the live pins instead of the captured byte. A fault in the handshake masking shows up on the next port C read, which returns a pin or latch level where a status bit belongs. It also shows up when a direct port C write silently changes an interrupt enable.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int DW = 8;
  localparam int SELW = $clog2(DW);

  typedef enum logic [1:0] {
    OFF_A   = 2'd0,
    OFF_B   = 2'd1,
    OFF_C   = 2'd2,
    OFF_CTL = 2'd3
  } pio_off_e;

  // port C bit positions used by the strobed groups
  localparam int A_REQ = 3;
  localparam int A_STB = 4;
  localparam int A_BF  = 5;
  localparam int B_REQ = 0;
  localparam int B_BF  = 1;
  localparam int B_STB = 2;

  typedef struct packed {
    logic strb_a;  // group A strobed mode
    logic in_a;    // port A input
    logic in_cu;   // port C upper input
    logic strb_b;  // group B strobed mode
    logic in_b;    // port B input
    logic in_cl;   // port C lower input
  } pio_cfg_t;

  localparam pio_cfg_t CFG_RESET = '{strb_a: 1'b0, in_a: 1'b1, in_cu: 1'b1,
                                     strb_b: 1'b0, in_b: 1'b1, in_cl: 1'b1};

  function automatic pio_cfg_t decode_cfg(logic [DW-1:0] w);
    pio_cfg_t c;
    c.strb_a = |w[6:5];
    c.in_a   = w[4];
    c.in_cu  = w[3];
    c.strb_b = w[2];
    c.in_b   = w[1];
    c.in_cl  = w[0];
    return c;
  endfunction

  // bits of port C taken over by strobed groups
  function automatic logic [DW-1:0] owned_mask(pio_cfg_t c);
    logic [DW-1:0] m;
    m = '0;
    if (c.strb_a) begin
      m[A_REQ] = 1'b1; m[A_STB] = 1'b1; m[A_BF] = 1'b1;
    end
    if (c.strb_b) begin
      m[B_REQ] = 1'b1; m[B_STB] = 1'b1; m[B_BF] = 1'b1;
    end
    return m;
  endfunction

  // port C bits driven because they are status outputs
  function automatic logic [DW-1:0] status_drive(pio_cfg_t c);
    logic [DW-1:0] m;
    m = '0;
    if (c.strb_a) begin m[A_REQ] = 1'b1; m[A_BF] = 1'b1; end
    if (c.strb_b) begin m[B_REQ] = 1'b1; m[B_BF] = 1'b1; end
    return m;
  endfunction

  // nibble-wise drive enables of port C in plain use
  function automatic logic [DW-1:0] c_plain_oe(pio_cfg_t c);
    return {{(DW/2){~c.in_cu}}, {(DW/2){~c.in_cl}}};
  endfunction
endpackage

// File: rtl/pio_cfg_reg.sv
module pio_cfg_reg
  import pio_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] c_owned,
  output pio_cfg_t      cfg,
  output logic [DW-1:0] lat_a,
  output logic [DW-1:0] lat_b,
  output logic [DW-1:0] lat_c,
  output logic          mode_wr
);
  logic ctl_wr, bit_wr;

  assign ctl_wr  = wr_en && (addr == OFF_CTL);
  assign mode_wr = ctl_wr && wdata[DW-1];
  assign bit_wr  = ctl_wr && !wdata[DW-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg   <= CFG_RESET;
      lat_a <= '0;
      lat_b <= '0;
      lat_c <= '0;
    end else if (mode_wr) begin
      cfg   <= decode_cfg(wdata);
      lat_a <= '0;
      lat_b <= '0;
      lat_c <= '0;
    end else if (bit_wr) begin
      lat_c[wdata[SELW:1]] <= wdata[0];
    end else if (wr_en) begin
      case (addr)
        OFF_A:   lat_a <= wdata;
        OFF_B:   lat_b <= wdata;
        OFF_C:   lat_c <= (lat_c & c_owned) | (wdata & ~c_owned);
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pio_strobe_chan.sv
module pio_strobe_chan
  import pio_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          clr,
  input  logic          stb_n,
  input  logic          rd_ack,
  input  logic          inte,
  input  logic [DW-1:0] pins,
  output logic [DW-1:0] held,
  output logic          full,
  output logic          req,
  output logic          cap
);
  logic stb_q, req_q, rise;

  assign cap  = en && stb_q && !stb_n;
  assign rise = en && !stb_q && stb_n;
  assign req  = req_q && inte;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stb_q <= 1'b1;
      held  <= '0;
      full  <= 1'b0;
      req_q <= 1'b0;
    end else begin
      stb_q <= stb_n;
      if (clr || !en) begin
        full  <= 1'b0;
        req_q <= 1'b0;
      end else if (cap) begin
        held <= pins;
        full <= 1'b1;
      end else if (rd_ack) begin
        full  <= 1'b0;
        req_q <= 1'b0;
      end else if (rise && full && inte) begin
        req_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pio_tri_port.sv
module pio_tri_port
  import pio_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    addr,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  input  logic [7:0]    pa_in,
  output logic [7:0]    pa_out,
  output logic [7:0]    pa_oe,
  input  logic [7:0]    pb_in,
  output logic [7:0]    pb_out,
  output logic [7:0]    pb_oe,
  input  logic [7:0]    pc_in,
  output logic [7:0]    pc_out,
  output logic [7:0]    pc_oe
);
  pio_cfg_t      cfg;
  logic [DW-1:0] lat_a, lat_b, lat_c, c_owned, c_stat, c_base;
  logic [DW-1:0] held_a, held_b, rd_c;
  logic          mode_wr, inte_a, inte_b;
  logic          full_a, full_b, req_a, req_b, cap_a, cap_b;
  logic          rd_a, rd_b;

  assign c_owned = owned_mask(cfg);
  assign c_base  = c_plain_oe(cfg);
  assign inte_a  = cfg.strb_a && lat_c[A_STB];
  assign inte_b  = cfg.strb_b && lat_c[B_STB];
  assign rd_a    = rd_en && (addr == OFF_A);
  assign rd_b    = rd_en && (addr == OFF_B);

  pio_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .c_owned(c_owned), .cfg(cfg), .lat_a(lat_a), .lat_b(lat_b),
    .lat_c(lat_c), .mode_wr(mode_wr)
  );

  pio_strobe_chan u_chan_a (
    .clk(clk), .rst_n(rst_n), .en(cfg.strb_a), .clr(mode_wr),
    .stb_n(pc_in[A_STB]), .rd_ack(rd_a), .inte(inte_a), .pins(pa_in),
    .held(held_a), .full(full_a), .req(req_a), .cap(cap_a)
  );

  pio_strobe_chan u_chan_b (
    .clk(clk), .rst_n(rst_n), .en(cfg.strb_b), .clr(mode_wr),
    .stb_n(pc_in[B_STB]), .rd_ack(rd_b), .inte(inte_b), .pins(pb_in),
    .held(held_b), .full(full_b), .req(req_b), .cap(cap_b)
  );

  always_comb begin
    c_stat        = '0;
    c_stat[A_REQ] = req_a;
    c_stat[A_STB] = inte_a;
    c_stat[A_BF]  = full_a;
    c_stat[B_REQ] = req_b;
    c_stat[B_BF]  = full_b;
    c_stat[B_STB] = inte_b;
  end

  assign pa_out = lat_a;
  assign pb_out = lat_b;
  assign pa_oe  = (!cfg.strb_a && !cfg.in_a) ? '1 : '0;
  assign pb_oe  = (!cfg.strb_b && !cfg.in_b) ? '1 : '0;
  assign pc_out = (lat_c & ~c_owned) | (c_stat & c_owned);
  assign pc_oe  = (c_base & ~c_owned) | status_drive(cfg);

  assign rd_c = (c_stat & c_owned) | (lat_c & c_base & ~c_owned)
              | (pc_in & ~c_base & ~c_owned);

  always_comb begin
    case (addr)
      OFF_A:   rdata = cfg.strb_a ? held_a : (cfg.in_a ? pa_in : lat_a);
      OFF_B:   rdata = cfg.strb_b ? held_b : (cfg.in_b ? pb_in : lat_b);
      OFF_C:   rdata = rd_c;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/pio_tri_port_chk.sv
module pio_tri_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] addr,
  input logic       wr_en,
  input logic       rd_en,
  input logic [7:0] wdata,
  input logic [7:0] pa_oe,
  input logic [7:0] pb_oe,
  input logic [7:0] pa_out,
  input logic [7:0] pb_out,
  input logic [7:0] pc_out,
  input logic [7:0] lat_c,
  input logic       strb_a,
  input logic       full_a,
  input logic       cap_a
);
  a_r2_byte_dir: assert property (@(posedge clk) disable iff (!rst_n)
    (pa_oe == 8'h00 || pa_oe == 8'hFF) && (pb_oe == 8'h00 || pb_oe == 8'hFF));

  a_r5_modeset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd3 && wdata[7])
      |=> (pa_out == 8'h00 && pb_out == 8'h00 && pc_out == 8'h00));

  a_r6_bit_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd3 && !wdata[7])
      |=> (lat_c[$past(wdata[3:1])] == $past(wdata[0])));

  a_r7_full_from_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(full_a) |-> $past(cap_a));

  a_r8_req_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
    (strb_a && pc_out[3]) |-> pc_out[5]);

  a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 2'd0 && strb_a && !cap_a) |=> !full_a);
endmodule

bind pio_tri_port pio_tri_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
  .wdata(wdata), .pa_oe(pa_oe), .pb_oe(pb_oe), .pa_out(pa_out),
  .pb_out(pb_out), .pc_out(pc_out), .lat_c(lat_c), .strb_a(cfg.strb_a),
  .full_a(full_a), .cap_a(cap_a)
);

// File: tb/pio_tri_port_bench.sv
module pio_tri_port_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = '0, rdata;
  logic [7:0] pa_in = '0, pb_in = '0, pc_in = 8'hFF;
  logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pio_tri_port u_pio_tri_port (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .pa_in(pa_in), .pa_out(pa_out),
    .pa_oe(pa_oe), .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
  );

  function automatic logic [7:0] byte_oe(logic in_bit);
    return in_bit ? 8'h00 : 8'hFF;
  endfunction
  function automatic logic [7:0] c_oe_of(logic [7:0] cw);
    return {{4{~cw[3]}}, {4{~cw[0]}}};
  endfunction
  function automatic logic [7:0] pick(logic [7:0] oe, logic [7:0] lat, logic [7:0] pin);
    return (oe & lat) | (~oe & pin);
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, logic [7:0] exp, string tag);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1 chk(tag, rdata, exp);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] cw, la, lb, lc, r;
    void'($urandom(32'h5EED));
    repeat (3) tick();
    // R1: reset state
    chk("R1 pa_oe", pa_oe, 8'h00);
    chk("R1 pb_oe", pb_oe, 8'h00);
    chk("R1 pc_oe", pc_oe, 8'h00);
    chk("R1 pc_out", pc_out, 8'h00);
    rst_n = 1'b1;
    tick();
    chk("R1 after release pa_out", pa_out, 8'h00);

    // R3: all-output and all-input words
    wr(2'd3, 8'h80);
    chk("R3 0x80 pa_oe", pa_oe, 8'hFF);
    chk("R3 0x80 pb_oe", pb_oe, 8'hFF);
    chk("R3 0x80 pc_oe", pc_oe, 8'hFF);
    wr(2'd0, 8'h55);
    chk("R2 pa_out", pa_out, 8'h55);
    wr(2'd3, 8'h9B);
    chk("R3 0x9B pc_oe", pc_oe, 8'h00);
    chk("R5 latch cleared", pa_out, 8'h00);

    // random plain-mode traffic
    for (int i = 0; i < 30; i++) begin
      cw = 8'h80 | (8'($urandom()) & 8'h1B);
      wr(2'd3, cw);
      la = 0; lb = 0; lc = 0;
      chk("R3 rnd pa_oe", pa_oe, byte_oe(cw[4]));
      chk("R3 rnd pb_oe", pb_oe, byte_oe(cw[1]));
      chk("R3 rnd pc_oe", pc_oe, c_oe_of(cw));
      chk("R5 rnd pc_out", pc_out, 8'h00);
      la = 8'($urandom()); lb = 8'($urandom()); lc = 8'($urandom());
      wr(2'd0, la); wr(2'd1, lb); wr(2'd2, lc);
      chk("R2 rnd pa_out", pa_out, la);
      chk("R2 rnd pb_out", pb_out, lb);
      chk("R2 rnd pc_out", pc_out, lc);
      r = 8'($urandom());
      wr(2'd3, {4'h0, r[2:0], r[3]});
      lc[r[2:0]] = r[3];
      chk("R6 rnd pc_out", pc_out, lc);
      pa_in = 8'($urandom()); pb_in = 8'($urandom()); pc_in = 8'($urandom());
      rd(2'd0, pick(byte_oe(cw[4]), la, pa_in), "R4 rnd read A");
      rd(2'd1, pick(byte_oe(cw[1]), lb, pb_in), "R4 rnd read B");
      rd(2'd2, pick(c_oe_of(cw), lc, pc_in), "R4 rnd read C");
    end

    // group A strobed input
    pc_in = 8'hFF; pa_in = 8'h3C;
    wr(2'd3, 8'hB0);
    chk("R7 pa_oe off", pa_oe, 8'h00);
    chk("R7 pc_oe status", pc_oe & 8'h38, 8'h28);
    wr(2'd3, 8'h09);
    pc_in[4] = 1'b0; tick();
    chk("R7 full set", {7'd0, pc_out[5]}, 8'h01);
    chk("R8 no req while low", {7'd0, pc_out[3]}, 8'h00);
    pa_in = 8'h11;
    pc_in[4] = 1'b1; tick();
    chk("R8 req raised", {7'd0, pc_out[3]}, 8'h01);
    rd(2'd2, 8'h38, "R11 status read C");
    rd(2'd0, 8'h3C, "R7 captured byte");
    chk("R9 full cleared", {7'd0, pc_out[5]}, 8'h00);
    chk("R9 req cleared", {7'd0, pc_out[3]}, 8'h00);
    wr(2'd3, 8'h08);
    pc_in[4] = 1'b0; tick();
    pc_in[4] = 1'b1; tick();
    chk("R8 disabled full", {7'd0, pc_out[5]}, 8'h01);
    chk("R8 disabled no req", {7'd0, pc_out[3]}, 8'h00);
    wr(2'd2, 8'hFF);
    rd(2'd2, 8'hE7, "R12 owned bits kept");

    // group B strobed input
    wr(2'd3, 8'h86);
    wr(2'd3, 8'h05);
    pb_in = 8'hA5;
    pc_in[2] = 1'b0; tick();
    chk("R10 full B", {7'd0, pc_out[1]}, 8'h01);
    pb_in = 8'h00;
    pc_in[2] = 1'b1; tick();
    chk("R10 req B", {7'd0, pc_out[0]}, 8'h01);
    chk("R10 pb_oe off", pb_oe, 8'h00);
    rd(2'd1, 8'hA5, "R10 captured B");
    chk("R10 B cleared", pc_out & 8'h03, 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule